// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers single-cycle event pulses from eleven leaf interrupt groups and condenses them into one master summary word. From that word it raises a single message-style interrupt request. Each leaf group owns four 32-bit registers: a live status view of its raw event inputs, a mask, a latched identity register and an enable. A fixed routing table folds each group's pending bits (identity AND enable) into master summary bits. Some groups are folded per 16-bit half and the others as a whole word.

Software reaches every register through a word-addressed port. Reads are combinational. Writes take effect at the clock edge. The master word carries one writable bit, bit 31, which is the global delivery enable. Its other bits are a live level that follows the leaf state and can be both set and cleared by it. A request pulse is sent only when bit 31 is set, at least one summary bit is set, and the message control input is in its single accepted format.

Top module: `irq_aggregator`

## Requirements
- R1: The word address is `{group[3:0], reg[1:0]}`. Groups 0..10 are, in order: engine groups E0, E1, E2, E3, display pipes A, B, C, display port, display misc, south, power control. The reg codes are: 0 status, 1 mask, 2 identity, 3 enable. The master word sits at address 60 (group 15, reg 0). Every other address reads zero.
- R2: After reset, identity, enable and master read zero, every mask reads 0xFFFFFFFF, and `irq_req` is low.
- R3: A status read returns that group's `evt_i` slice in the same cycle. Writes to status change nothing.
- R4: An event bit sets the matching identity bit at the next edge only if that mask bit is 0. A masked event leaves the identity register unchanged.
- R5: Writing identity clears each bit written as 1 and keeps each bit written as 0. If an unmasked event arrives on the same bit in the same cycle, the event wins and the bit stays set.
- R6: Master summary bits are computed from pending = identity & enable. Bit 0 is E0[15:0], bit 1 is E0[31:16], bit 2 is E1[15:0], bit 3 is E1[31:16], bit 4 is E2[15:0] and bit 6 is E3[15:0]. Bits 16, 17 and 18 are pipes A, B and C, bit 20 is port, bit 22 is misc, bit 23 is south and bit 30 is power control; each of these uses all 32 bits. The upper halves of E2 and E3 reach no bit.
- R7: A summary bit is a live level. It drops as soon as its pending bits are removed, either by clearing identity or by clearing enable.
- R8: Only bit 31 of the master word is writable. Writes to bits 30..0 are ignored.
- R9: `irq_req` pulses high for one cycle, in the cycle after the edge at which the gated summary (bit 31 AND any summary bit) goes from zero to non-zero.
- R10: While the gated summary is non-zero, any register write to a mask, identity, enable or master address, or any event pulse, produces a new one-cycle pulse in the following cycle.
- R11: While master bit 31 is 0, `irq_req` stays low whatever the summary holds.
- R12: `irq_req` is issued only when `msg_ctrl` equals 0x0001. Bit 0 is the message enable, and any set bit in 15..1 rejects the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 352 | Event pulses, 32 per group, group g at bits [32g+31:32g] |
| msg_ctrl | input | 16 | Message control format word |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| irq_req | output | 1 | One-cycle interrupt request pulse |

## Verification
Read data is combinational, so the bench compares `reg_rdata` shortly after it drives an address, before the next rising edge. A write or event commits at the next rising edge. Any pulse it causes on `irq_req` therefore appears in the following cycle and is gone one cycle later. For this reason the bench checks the expected pulse level at the falling edge after each operation's commit edge, before it drives the next operation. The one case that needs two inputs in a single cycle is an event arriving together with a clear of the same bit; the bench drives both in one cycle and reads identity back one cycle later.

// File: rtl/irq_aggregator.sv
module irq_aggregator (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [351:0] evt_i,
  input  logic [15:0]  msg_ctrl,
  input  logic         reg_we,
  input  logic [5:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  output logic         irq_req
);
  localparam int NG = 11;
  localparam int DW = 32;
  localparam logic [3:0] MASTER_GRP = 4'd15;

  logic [3:0] a_grp;
  logic [1:0] a_reg;
  logic       grp_ok, wr_mst, wr_any;
  logic [DW-1:0] mask_r [NG];
  logic [DW-1:0] id_r   [NG];
  logic [DW-1:0] en_r   [NG];
  logic [DW-1:0] pend   [NG];
  logic [30:0] sum;
  logic gie_r, gated, gated_q, recheck_q, msg_ok;

  assign a_grp  = reg_addr[5:2];
  assign a_reg  = reg_addr[1:0];
  assign grp_ok = a_grp < 4'(NG);
  assign wr_mst = reg_we && a_grp == MASTER_GRP && a_reg == 2'd0;
  assign wr_any = (reg_we && grp_ok && a_reg != 2'd0) || wr_mst;

  always_comb
    for (int g = 0; g < NG; g++) pend[g] = id_r[g] & en_r[g];

  always_comb begin
    sum     = '0;
    sum[0]  = |pend[0][15:0];
    sum[1]  = |pend[0][31:16];
    sum[2]  = |pend[1][15:0];
    sum[3]  = |pend[1][31:16];
    sum[4]  = |pend[2][15:0];
    sum[6]  = |pend[3][15:0];
    sum[16] = |pend[4];
    sum[17] = |pend[5];
    sum[18] = |pend[6];
    sum[20] = |pend[7];
    sum[22] = |pend[8];
    sum[23] = |pend[9];
    sum[30] = |pend[10];
  end

  assign gated   = gie_r & (|sum);
  assign msg_ok  = msg_ctrl == 16'h0001;
  assign irq_req = msg_ok & gated & (~gated_q | recheck_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin
        mask_r[g] <= '1;
        id_r[g]   <= '0;
        en_r[g]   <= '0;
      end
      gie_r     <= 1'b0;
      gated_q   <= 1'b0;
      recheck_q <= 1'b0;
    end else begin
      for (int g = 0; g < NG; g++) begin
        if (reg_we && a_grp == 4'(g) && a_reg == 2'd1) mask_r[g] <= reg_wdata;
        if (reg_we && a_grp == 4'(g) && a_reg == 2'd3) en_r[g]   <= reg_wdata;
        id_r[g] <= (id_r[g] & ~((reg_we && a_grp == 4'(g) && a_reg == 2'd2) ? reg_wdata : '0))
                 | (evt_i[g*DW +: DW] & ~mask_r[g]);
      end
      if (wr_mst) gie_r <= reg_wdata[31];
      gated_q   <= gated;
      recheck_q <= wr_any | (|evt_i);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (grp_ok) begin
      case (a_reg)
        2'd0:    reg_rdata = evt_i[a_grp*DW +: DW];
        2'd1:    reg_rdata = mask_r[a_grp];
        2'd2:    reg_rdata = id_r[a_grp];
        default: reg_rdata = en_r[a_grp];
      endcase
    end else if (a_grp == MASTER_GRP && a_reg == 2'd0) begin
      reg_rdata = {gie_r, sum};
    end
  end

  for (genvar gv = 0; gv < NG; gv++) begin : g_chk
    p_masked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (~|(evt_i[gv*DW +: DW] & ~mask_r[gv]) && !(reg_we && a_grp == 4'(gv) && a_reg == 2'd2))
      |=> $stable(id_r[gv]));
  end

  p_gie_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mst |=> $stable(gie_r));

  p_rise_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gated) && msg_ctrl == 16'h0001) |-> irq_req);

  p_irq_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (|reg_rdata_sum_chk));

  p_irq_gie_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gie_r);

  p_irq_msg_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (msg_ctrl[0] && msg_ctrl[15:1] == 15'd0));

  logic [30:0] reg_rdata_sum_chk;
  assign reg_rdata_sum_chk = sum;
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  localparam int CLK_PER = 10;
  localparam logic [1:0] OP_R = 2'd0, OP_W = 2'd1, OP_E = 2'd2;
  localparam int NV = 47;
  // {req[3:0], op[1:0], exp_irq, addr[5:0], data[31:0]}
  localparam logic [44:0] VEC [NV] = '{
    {4'd2,  OP_R, 1'b0, 6'd1,  32'hFFFFFFFF},  // R2 mask reset
    {4'd2,  OP_R, 1'b0, 6'd2,  32'h00000000},  // R2
    {4'd2,  OP_R, 1'b0, 6'd3,  32'h00000000},  // R2
    {4'd2,  OP_R, 1'b0, 6'd60, 32'h00000000},  // R2
    {4'd4,  OP_E, 1'b0, 6'd0,  32'h00000001},  // R4 masked event
    {4'd4,  OP_R, 1'b0, 6'd2,  32'h00000000},  // R4
    {4'd4,  OP_W, 1'b0, 6'd1,  32'hFFFF0000},  // R4
    {4'd6,  OP_W, 1'b0, 6'd3,  32'hFFFFFFFF},  // R6
    {4'd4,  OP_E, 1'b0, 6'd0,  32'h00010011},  // R4 bit16 masked
    {4'd4,  OP_R, 1'b0, 6'd2,  32'h00000011},  // R4
    {4'd6,  OP_R, 1'b0, 6'd60, 32'h00000001},  // R6
    {4'd8,  OP_W, 1'b0, 6'd60, 32'h7FFFFFFF},  // R8
    {4'd8,  OP_R, 1'b0, 6'd60, 32'h00000001},  // R8
    {4'd9,  OP_W, 1'b1, 6'd60, 32'h80000000},  // R9 rise
    {4'd9,  OP_R, 1'b0, 6'd60, 32'h80000001},  // R9
    {4'd10, OP_W, 1'b1, 6'd2,  32'h00000001},  // R10
    {4'd5,  OP_R, 1'b0, 6'd2,  32'h00000010},  // R5
    {4'd10, OP_W, 1'b1, 6'd1,  32'h00000000},  // R10 mask write
    {4'd7,  OP_W, 1'b0, 6'd2,  32'h00000010},  // R7
    {4'd7,  OP_R, 1'b0, 6'd60, 32'h80000000},  // R7
    {4'd4,  OP_W, 1'b0, 6'd13, 32'h00000000},  // R4
    {4'd6,  OP_W, 1'b0, 6'd15, 32'hFFFFFFFF},  // R6
    {4'd6,  OP_E, 1'b0, 6'd12, 32'h00010000},  // R6 unrouted half
    {4'd6,  OP_R, 1'b0, 6'd14, 32'h00010000},  // R6
    {4'd6,  OP_R, 1'b0, 6'd60, 32'h80000000},  // R6
    {4'd9,  OP_E, 1'b1, 6'd12, 32'h00000004},  // R9
    {4'd6,  OP_R, 1'b0, 6'd60, 32'h80000040},  // R6
    {4'd7,  OP_W, 1'b0, 6'd15, 32'h00000000},  // R7 enable off
    {4'd7,  OP_R, 1'b0, 6'd60, 32'h80000000},  // R7
    {4'd4,  OP_W, 1'b0, 6'd41, 32'h00000000},  // R4
    {4'd6,  OP_W, 1'b0, 6'd43, 32'h00000001},  // R6
    {4'd9,  OP_E, 1'b1, 6'd40, 32'h00000001},  // R9
    {4'd6,  OP_R, 1'b0, 6'd60, 32'hC0000000},  // R6
    {4'd10, OP_E, 1'b1, 6'd40, 32'h00000001},  // R10 event recheck
    {4'd11, OP_W, 1'b0, 6'd60, 32'h00000000},  // R11
    {4'd11, OP_E, 1'b0, 6'd40, 32'h00000001},  // R11
    {4'd11, OP_R, 1'b0, 6'd60, 32'h40000000},  // R11
    {4'd6,  OP_W, 1'b0, 6'd17, 32'h00000000},  // R6
    {4'd6,  OP_W, 1'b0, 6'd19, 32'h80000000},  // R6
    {4'd11, OP_E, 1'b0, 6'd16, 32'h80000000},  // R11
    {4'd6,  OP_R, 1'b0, 6'd60, 32'h40010000},  // R6
    {4'd3,  OP_W, 1'b0, 6'd40, 32'hFFFFFFFF},  // R3 status write
    {4'd3,  OP_R, 1'b0, 6'd40, 32'h00000000},  // R3
    {4'd1,  OP_R, 1'b0, 6'd44, 32'h00000000},  // R1 unmapped
    {4'd1,  OP_R, 1'b0, 6'd61, 32'h00000000},  // R1
    {4'd1,  OP_R, 1'b0, 6'd26, 32'h00000000},  // R1
    {4'd1,  OP_R, 1'b0, 6'd7,  32'h00000000}   // R1
  };

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, irq_req;
  logic [351:0] evt = '0;
  logic [15:0] msg_ctrl = 16'h0001;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int total = 0, bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  irq_aggregator u0 (.clk(clk), .rst_n(rst_n), .evt_i(evt), .msg_ctrl(msg_ctrl),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req));

  task automatic chk(input logic ok, input int req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [5:0] addr, input logic [31:0] data,
                        input logic exp_irq, input int req);
    reg_addr = addr; reg_wdata = data; reg_we = (op == OP_W); evt = '0;
    if (op == OP_E) evt[addr[5:2]*32 +: 32] = data;
    if (op == OP_R) begin
      #1;
      chk(reg_rdata == data, req, reg_rdata, data);
    end
    @(negedge clk);
    reg_we = 1'b0; evt = '0;
    chk(irq_req == exp_irq, req, 32'(irq_req), 32'(exp_irq));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(irq_req == 1'b0, 2, 32'(irq_req), 0);  // R2
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++)
      run_op(VEC[i][40:39], VEC[i][37:32], VEC[i][31:0], VEC[i][38], int'(VEC[i][44:41]));

    // R3: status shows live events; masked event does not latch (R4)
    reg_addr = 6'd8; evt[2*32+7] = 1'b1; #1;
    chk(reg_rdata == 32'h80, 3, reg_rdata, 32'h80);
    @(negedge clk); evt = '0;
    run_op(OP_R, 6'd10, 32'h0, 1'b0, 4);

    // R12: message format gating
    msg_ctrl = 16'h0000;
    run_op(OP_W, 6'd60, 32'h80000000, 1'b0, 12);
    msg_ctrl = 16'h0003;
    run_op(OP_W, 6'd42, 32'h0, 1'b0, 12);
    msg_ctrl = 16'h0001;
    run_op(OP_W, 6'd42, 32'h0, 1'b1, 12);

    // R5: event wins over same-cycle clear
    reg_addr = 6'd42; reg_wdata = 32'h1; reg_we = 1'b1; evt[10*32] = 1'b1;
    @(negedge clk); reg_we = 1'b0; evt = '0;
    chk(irq_req == 1'b1, 10, 32'(irq_req), 1);  // R10
    run_op(OP_R, 6'd42, 32'h1, 1'b0, 5);

    // R2: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk(irq_req == 1'b0, 2, 32'(irq_req), 0);
    rst_n = 1'b1;
    run_op(OP_R, 6'd41, 32'hFFFFFFFF, 1'b0, 2);
    run_op(OP_R, 6'd60, 32'h0, 1'b0, 2);
    run_op(OP_R, 6'd42, 32'h0, 1'b0, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule